// File: doc/BRIEF.md
# Overlapped-Fetch Accumulator Core

This block is a small 8-bit accumulator processor with one synchronous memory port. Memory returns read data in the cycle after the address is presented. The core relies on that latency to overlap work. While an opcode arrives and is decoded, the byte after it is already being addressed and the program counter moves past it. The arithmetic and the accumulator update of an instruction are done in the same cycle that addresses the opcode of the next one. As a result, immediate instructions take two clocks and zero-page loads and stores take three.

The core accepts five opcodes:

| Instruction | Opcode |
|---|---|
| load immediate | `0xA9` |
| add-with-carry immediate | `0x69` |
| load from zero page | `0xA5` |
| store to zero page | `0x85` |
| no-operation | `0xEA` |

Every other byte executes as a two-cycle no-operation. The carry bit is the only status kept. Zero page is the 256 bytes whose upper address byte is zero, and it is selected by a one-byte operand.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core returns to its initial state. In the first cycle after `rst` falls, `fetch_o` is 1, `mem_addr` is 0x0200, `mem_we` is 0, and both `acc_o` and `carry_o` are 0.
- R2: Load immediate (0xA9 followed by a value byte) takes 2 cycles from its opcode fetch to the next opcode fetch. After it, `acc_o` holds the value byte and `carry_o` is unchanged.
- R3: Add-with-carry immediate (0x69 followed by a value byte) takes 2 cycles. The new accumulator is (A + value + C) mod 256, and the new carry is bit 8 of that sum.
- R4: Load from zero page (0xA5 followed by an address byte z) takes 3 cycles. In its third cycle it reads address 0x00zz with `mem_we` low. After it, `acc_o` holds the byte stored at 0x00zz and the carry is unchanged.
- R5: Store to zero page (0x85 followed by z) takes 3 cycles. In the third cycle it drives `mem_addr` = 0x00zz, `mem_we` = 1 and `mem_wdata` = A. The accumulator and carry are left as they were, and the next cycle is an opcode fetch.
- R6: Opcode 0xEA and any byte other than the four opcodes above take 2 cycles. They leave A and C unchanged, and the next opcode is fetched from the address one above the opcode.
- R7: `mem_we` is 1 only in the third cycle of a zero-page store. Whenever it is 1, the upper address byte is zero.
- R8: The cycle after each opcode fetch always addresses the opcode address plus one, and is never itself an opcode fetch.
- R9: A zero-page load followed by a zero-page store spans 6 cycles. The stored byte equals the loaded byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory address for this cycle |
| mem_rdata | input | 8 | Byte read at the address of the previous cycle |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| fetch_o | output | 1 | High in opcode fetch cycles |
| acc_o | output | 8 | Accumulator register |
| carry_o | output | 1 | Carry register |

## Verification
The assertions take two things for granted about the inputs. First, the memory returns the byte for an address exactly one cycle later. Second, `rst` is synchronous and is held through at least one edge. The checks also assume every opcode byte the core reads is a defined value. The bench writes the program and its zero-page data into its memory model through a load port while reset is held. It then pads the end of the program with no-operation bytes, so that every byte the core fetches has been written.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_LDI = 8'hA9;
    localparam logic [OPC_W-1:0] OPC_ADI = 8'h69;
    localparam logic [OPC_W-1:0] OPC_LDZ = 8'hA5;
    localparam logic [OPC_W-1:0] OPC_STZ = 8'h85;
    localparam logic [OPC_W-1:0] OPC_NOP = 8'hEA;

    // cycle role of the core
    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_ZPAGE  = 2'd2
    } phase_e;

    // work carried over into the next fetch cycle
    typedef enum logic [1:0] {
        EX_NONE = 2'd0,
        EX_LOAD = 2'd1,
        EX_ADD  = 2'd2
    } exec_e;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_LDI = 3'd1,
        OP_ADI = 3'd2,
        OP_LDZ = 3'd3,
        OP_STZ = 3'd4
    } opclass_e;

endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
    import acc_core_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output opclass_e         cls
);
    always_comb begin
        case (opcode)
            OPC_LDI: cls = OP_LDI;
            OPC_ADI: cls = OP_ADI;
            OPC_LDZ: cls = OP_LDZ;
            OPC_STZ: cls = OP_STZ;
            default: cls = OP_NOP;   // 0xEA and all unknown bytes (R6)
        endcase
    end
endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  exec_e             op,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              carry_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic [DATA_W-1:0] acc_o,
    output logic              carry_o
);
    logic [DATA_W:0] sum;

    assign sum = {1'b0, acc_i} + {1'b0, operand_i} + {{DATA_W{1'b0}}, carry_i};

    always_comb begin
        acc_o   = acc_i;
        carry_o = carry_i;
        case (op)
            EX_LOAD: acc_o = operand_i;
            EX_ADD: begin
                acc_o   = sum[DATA_W-1:0];
                carry_o = sum[DATA_W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h0200
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              fetch_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              carry_o
);
    localparam int PAGE_W = ADDR_W - DATA_W;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] acc;
        logic              carry;
        exec_e             pend;
        logic              zp_store;
    } core_state_t;

    core_state_t q, d;

    opclass_e          cls;
    logic [DATA_W-1:0] alu_acc;
    logic              alu_carry;

    acc_core_decode u_decode (
        .opcode (mem_rdata[OPC_W-1:0]),
        .cls    (cls)
    );

    acc_core_alu #(.DATA_W(DATA_W)) u_alu (
        .op        (q.pend),
        .acc_i     (q.acc),
        .carry_i   (q.carry),
        .operand_i (mem_rdata),
        .acc_o     (alu_acc),
        .carry_o   (alu_carry)
    );

    always_comb begin
        d         = q;
        mem_addr  = q.pc;
        mem_we    = 1'b0;
        mem_wdata = q.acc;
        case (q.phase)
            ST_FETCH: begin
                // finish the previous instruction while addressing the next opcode
                d.acc   = alu_acc;
                d.carry = alu_carry;
                d.pend  = EX_NONE;
                d.pc    = q.pc + 1'b1;
                d.phase = ST_DECODE;
            end
            ST_DECODE: begin
                // opcode arrives; the following byte is addressed now
                d.phase = ST_FETCH;
                case (cls)
                    OP_LDI: begin
                        d.pc   = q.pc + 1'b1;
                        d.pend = EX_LOAD;
                    end
                    OP_ADI: begin
                        d.pc   = q.pc + 1'b1;
                        d.pend = EX_ADD;
                    end
                    OP_LDZ: begin
                        d.pc       = q.pc + 1'b1;
                        d.zp_store = 1'b0;
                        d.phase    = ST_ZPAGE;
                    end
                    OP_STZ: begin
                        d.pc       = q.pc + 1'b1;
                        d.zp_store = 1'b1;
                        d.phase    = ST_ZPAGE;
                    end
                    default: ;
                endcase
            end
            ST_ZPAGE: begin
                mem_addr = {{PAGE_W{1'b0}}, mem_rdata};
                mem_we   = q.zp_store;
                if (!q.zp_store) begin
                    d.pend = EX_LOAD;
                end
                d.phase = ST_FETCH;
            end
            default: d.phase = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{phase: ST_FETCH, pc: RESET_PC, acc: '0, carry: 1'b0,
                   pend: EX_NONE, zp_store: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign fetch_o = (q.phase == ST_FETCH);
    assign acc_o   = q.acc;
    assign carry_o = q.carry;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h0200
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              fetch_o,
    input logic [DATA_W-1:0] acc_o,
    input logic              carry_o
);
    AST_FIRST_FETCH: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (fetch_o && mem_addr == RESET_PC && !mem_we)); // R1

    AST_WE_PAGE_ZERO: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[ADDR_W-1:DATA_W] == '0)); // R7

    AST_NO_WE_ON_FETCH: assert property (@(posedge clk) disable iff (rst)
        fetch_o |-> !mem_we); // R7

    AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == acc_o)); // R5

    AST_STORE_KEEPS_REGS: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> ($stable(acc_o) && $stable(carry_o))); // R5

    AST_STORE_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> fetch_o); // R5

    AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        fetch_o |=> !fetch_o); // R8

    AST_OPERAND_ADDR: assert property (@(posedge clk) disable iff (rst)
        fetch_o |=> (mem_addr == $past(mem_addr) + 1'b1)); // R8
endmodule

bind acc_core acc_core_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RESET_PC (RESET_PC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .fetch_o   (fetch_o),
    .acc_o     (acc_o),
    .carry_o   (carry_o)
);

// File: tb/acc_core_test.sv
module acc_core_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        fetch_o;
    logic [7:0]  acc_o;
    logic        carry_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    acc_core uut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .fetch_o   (fetch_o),
        .acc_o     (acc_o),
        .carry_o   (carry_o)
    );

    // memory model: registered read, load port used while reset is held
    logic [7:0]  mem [0:4095];
    logic        ld_en = 1'b0;
    logic [11:0] ld_a  = '0;
    logic [7:0]  ld_d  = '0;

    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr[11:0]];
        if (ld_en) mem[ld_a] <= ld_d;
        else if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end

    typedef struct {
        int       len;
        logic [7:0] a;
        logic     c;
        string    tag;
    } item_t;

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  data;
        string       tag;
    } store_t;

    item_t  exp_q[$];
    store_t st_q[$];

    int checks = 0;
    int errors = 0;

    logic [7:0]  ref_a = 8'h00;
    logic        ref_c = 1'b0;
    logic [7:0]  ref_zp [0:255];
    logic [15:0] wr_pc = 16'h0200;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic put_byte(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        ld_en = 1'b1;
        ld_a  = a[11:0];
        ld_d  = v;
    endtask

    task automatic emit(input logic [7:0] b);
        put_byte(wr_pc, b);
        wr_pc = wr_pc + 16'd1;
    endtask

    task automatic push(input int len, input string tag);
        item_t it;
        it.len = len; it.a = ref_a; it.c = ref_c; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic drv_lda_imm(input logic [7:0] v);
        emit(8'hA9); emit(v);
        ref_a = v;
        push(2, "R2");
    endtask

    task automatic drv_adc_imm(input logic [7:0] v);
        logic [8:0] s;
        emit(8'h69); emit(v);
        s = {1'b0, ref_a} + {1'b0, v} + {8'd0, ref_c};
        ref_a = s[7:0];
        ref_c = s[8];
        push(2, "R3");
    endtask

    task automatic drv_lda_zp(input logic [7:0] z, input string tag);
        emit(8'hA5); emit(z);
        ref_a = ref_zp[z];
        push(3, tag);
    endtask

    task automatic drv_sta_zp(input logic [7:0] z, input string tag);
        store_t s;
        emit(8'h85); emit(z);
        ref_zp[z] = ref_a;
        s.addr = {8'h00, z}; s.data = ref_a; s.tag = "R5";
        st_q.push_back(s);
        push(3, tag);
    endtask

    task automatic drv_nop(input logic [7:0] op);
        emit(op);
        push(2, "R6");
    endtask

    // driver: program and reference expectations
    initial begin
        for (int i = 0; i < 256; i++) ref_zp[i] = 8'h00;
        put_byte(16'h0030, 8'h5A); ref_zp[8'h30] = 8'h5A;
        put_byte(16'h0010, 8'h00);
        drv_lda_imm(8'h3C);
        drv_adc_imm(8'hD0);          // carry out
        drv_adc_imm(8'h01);          // carry in consumed
        drv_sta_zp(8'h10, "R5");
        drv_lda_imm(8'hFF);
        drv_adc_imm(8'h01);          // wraps to zero
        drv_nop(8'hEA);
        drv_nop(8'h02);              // unknown opcode
        drv_adc_imm(8'hFF);
        drv_lda_zp(8'h10, "R4");
        drv_sta_zp(8'h20, "R9");
        drv_lda_zp(8'h30, "R9");
        drv_sta_zp(8'h31, "R9");
        drv_adc_imm(8'h00);
        drv_nop(8'h13);
        for (int i = 0; i < 8; i++) emit(8'hEA);
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    end

    // monitor / scoreboard
    initial begin
        int          cyc;
        int          last;
        bit          chk_next;
        bit          have_item;
        logic [15:0] fa;
        item_t       cur;
        store_t      st;
        wait (rst == 1'b0);
        #1;
        check(fetch_o == 1'b1, "R1", "fetch after reset", fetch_o, 1);
        check(mem_addr == 16'h0200, "R1", "reset address", mem_addr, 16'h0200);
        check(mem_we == 1'b0, "R1", "write strobe at reset", mem_we, 0);
        check(acc_o == 8'h00, "R1", "accumulator at reset", acc_o, 0);
        check(carry_o == 1'b0, "R1", "carry at reset", carry_o, 0);
        cyc = 0; last = 0; fa = mem_addr; chk_next = 1'b1; have_item = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (chk_next) begin
                check(mem_addr == fa + 16'd1, "R8", "operand address", mem_addr, fa + 16'd1);
                check(fetch_o == 1'b0, "R8", "decode cycle flag", fetch_o, 0);
                if (have_item) begin
                    check(acc_o == cur.a, cur.tag, "accumulator", acc_o, cur.a);
                    check(carry_o == cur.c, cur.tag, "carry", carry_o, cur.c);
                end
                chk_next = 1'b0;
                if (exp_q.size() == 0 && have_item) break;
            end
            if (mem_we) begin
                if (st_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected write", mem_addr, 0);
                end else begin
                    st = st_q.pop_front();
                    check(mem_addr == st.addr, "R7", "store address", mem_addr, st.addr);
                    check(mem_wdata == st.data, "R5", "store data", mem_wdata, st.data);
                end
            end
            if (fetch_o) begin
                if (exp_q.size() != 0) begin
                    cur = exp_q.pop_front();
                    have_item = 1'b1;
                    check(cyc - last == cur.len, cur.tag, "cycle count", cyc - last, cur.len);
                end
                last = cyc; fa = mem_addr; chk_next = 1'b1;
            end
        end
        check(st_q.size() == 0, "R5", "stores left over", st_q.size(), 0);
        check(mem[12'h010] == 8'h0E, "R5", "mem[0x10]", mem[12'h010], 8'h0E);
        check(mem[12'h020] == 8'h0E, "R9", "mem[0x20]", mem[12'h020], 8'h0E);
        check(mem[12'h031] == 8'h5A, "R9", "mem[0x31]", mem[12'h031], 8'h5A);
        finish_run();
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end
endmodule